// File: doc/BRIEF.md
# Bus-Master DMA Register File

This block keeps the bus-master control state for a two-channel disk controller. Each channel has three registers: a command byte, a status byte and a descriptor table pointer. Software reaches them through a simple register port that carries an access size with every write. The block enforces the access rules of each register. It turns edges of the command run bit into one-cycle start and abort pulses for the DMA engine of the drive that the channel has selected. It also takes a completion pulse back from that engine.

Reads are combinational from the register state. Writes take effect at the clock edge. Per channel, the start or abort pulse, the drive index it targets and the descriptor pointer are all visible on the output pins in the same cycle as the register update.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset every command byte and every pointer reads 0, and every status byte reads 0x60 (both drive-capable flags set, bits 5 and 6). Channel c occupies addresses 8*c to 8*c+7, with the command byte at offset 0, the status byte at offset 2 and the pointer at offset 4. Read data is zero-extended, and any other offset reads 0.
- R2: While `bm_en` is low, no write changes any register and no start or abort pulse appears.
- R3: The command byte changes only on a byte-size write (`req_size` 0). A half-word (1) or word (2) write to it is ignored.
- R4: While the command run bit (bit 0) is 1, a write keeps the direction bit (bit 3) at its old value. All other written bits are taken.
- R5: A command write that takes the run bit from 0 to 1 sets the status active bit (bit 0). In the next cycle it raises `dma_start` for that channel for one cycle, with `dma_unit` equal to the channel's `drv_sel` and `dma_ptr` holding the channel's pointer.
- R6: A command write that takes the run bit from 1 to 0 clears the active bit and raises `dma_abort` for one cycle, with `dma_unit` equal to `drv_sel`.
- R7: The status active bit cannot be changed by a status write.
- R8: The status error bit (bit 1) and interrupt bit (bit 2) clear when written with 1 and are unchanged when written with 0. Status bits 3 to 7 take the written value. The status byte accepts only byte-size writes.
- R9: The pointer changes only on a word-size write, and its two low bits are stored as 0.
- R10: A `dma_done` pulse on a channel clears that channel's run and active bits and sets its interrupt bit.
- R11: If `dma_done` arrives in the same cycle as a status write of 1 to the interrupt bit, the interrupt bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_en | input | 1 | Bus mastering enabled; writes are dropped when low |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Register selected by `req_addr`, zero-extended |
| drv_sel | input | NUM_CH | Selected drive per channel |
| dma_done | input | NUM_CH | Completion pulse per channel |
| dma_start | output | NUM_CH | One-cycle start pulse per channel |
| dma_abort | output | NUM_CH | One-cycle abort pulse per channel |
| dma_unit | output | NUM_CH | Drive index that goes with the last pulse |
| dma_ptr | output | 32*NUM_CH | Descriptor pointer per channel |

## Verification
The bench uses the default build: two channels and a four-bit address. Both channel slices and the channel-select address bit are therefore exercised, and a stray write to one channel would show up in the other channel's readback. Random traffic mixes legal and illegal sizes, odd offsets and the bus-master gate, with completion pulses landing at random. This produces the overlaps of command, status and completion in the same cycle that directed cases alone seldom reach.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_W   = 8;
    localparam int CH_SPAN = 3;          // log2 of bytes per channel window

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;

    localparam logic [2:0] OFS_CMD = 3'd0;
    localparam logic [2:0] OFS_STS = 3'd2;
    localparam logic [2:0] OFS_PTR = 3'd4;

    localparam logic [REG_W-1:0] STS_RESET = 8'h60;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic cmd_wr;
        logic sts_wr;
        logic ptr_wr;
    } chan_wr_t;

    // direction is frozen while the run bit is held
    function automatic logic [REG_W-1:0] cmd_merge(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] wr);
        logic [REG_W-1:0] r;
        r = wr;
        if (cur[CMD_RUN]) r[CMD_DIR] = cur[CMD_DIR];
        return r;
    endfunction

    // active is read-only, error and interrupt clear on a written one
    function automatic logic [REG_W-1:0] sts_merge(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] wr);
        logic [REG_W-1:0] r;
        r = wr;
        r[ST_ACT] = cur[ST_ACT];
        r[ST_ERR] = cur[ST_ERR] & ~wr[ST_ERR];
        r[ST_IRQ] = cur[ST_IRQ] & ~wr[ST_IRQ];
        return r;
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                  bm_en,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    output chan_wr_t [NUM_CH-1:0] wr
);
    localparam int CH_IDX_W = ADDR_W - CH_SPAN;

    logic [CH_IDX_W-1:0] ch_idx;
    logic [2:0]          ofs;
    acc_size_e           sz;
    logic                wr_ok;

    assign ch_idx = req_addr[ADDR_W-1:CH_SPAN];
    assign ofs    = req_addr[CH_SPAN-1:0];
    assign sz     = acc_size_e'(req_size);
    assign wr_ok  = bm_en & req_valid & req_write;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr[c].cmd_wr = wr_ok && (ch_idx == CH_IDX_W'(c)) && (ofs == OFS_CMD) && (sz == SZ_BYTE);
            wr[c].sts_wr = wr_ok && (ch_idx == CH_IDX_W'(c)) && (ofs == OFS_STS) && (sz == SZ_BYTE);
            wr[c].ptr_wr = wr_ok && (ch_idx == CH_IDX_W'(c)) && (ofs == OFS_PTR) && (sz == SZ_WORD);
        end
    end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              drv_sel,
    output logic [REG_W-1:0]  cmd_q,
    output logic [REG_W-1:0]  sts_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic              start_p,
    output logic              abort_p,
    output logic              unit_q
);
    logic [REG_W-1:0]  cmd_n, sts_n, cmd_m;
    logic [DATA_W-1:0] ptr_n;
    logic              go, stop;

    always_comb begin
        cmd_n = cmd_q;
        sts_n = sts_q;
        ptr_n = ptr_q;
        go    = 1'b0;
        stop  = 1'b0;
        cmd_m = cmd_merge(cmd_q, wdata[REG_W-1:0]);
        if (wr.cmd_wr) begin
            if (!cmd_q[CMD_RUN] && cmd_m[CMD_RUN]) begin
                go            = 1'b1;
                sts_n[ST_ACT] = 1'b1;
            end
            if (cmd_q[CMD_RUN] && !cmd_m[CMD_RUN]) begin
                stop          = 1'b1;
                sts_n[ST_ACT] = 1'b0;
            end
            cmd_n = cmd_m;
        end
        if (wr.sts_wr) sts_n = sts_merge(sts_q, wdata[REG_W-1:0]);
        if (wr.ptr_wr) ptr_n = wdata & ~DATA_W'(3);
        // completion is applied last so it wins over any write
        if (done) begin
            cmd_n[CMD_RUN] = 1'b0;
            sts_n[ST_ACT]  = 1'b0;
            sts_n[ST_IRQ]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            sts_q   <= STS_RESET;
            ptr_q   <= '0;
            start_p <= 1'b0;
            abort_p <= 1'b0;
            unit_q  <= 1'b0;
        end else begin
            cmd_q   <= cmd_n;
            sts_q   <= sts_n;
            ptr_q   <= ptr_n;
            start_p <= go & ~done;
            abort_p <= stop;
            if (go | stop) unit_q <= drv_sel;
        end
    end
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CH*REG_W-1:0]  cmd_all,
    input  logic [NUM_CH*REG_W-1:0]  sts_all,
    input  logic [NUM_CH*DATA_W-1:0] ptr_all,
    output logic [DATA_W-1:0]        rdata
);
    localparam int CH_IDX_W = ADDR_W - CH_SPAN;

    logic [CH_IDX_W-1:0] ch_idx;
    logic [2:0]          ofs;

    assign ch_idx = addr[ADDR_W-1:CH_SPAN];
    assign ofs    = addr[CH_SPAN-1:0];

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_IDX_W'(c)) begin
                case (ofs)
                    OFS_CMD: rdata = DATA_W'(cmd_all[c*REG_W +: REG_W]);
                    OFS_STS: rdata = DATA_W'(sts_all[c*REG_W +: REG_W]);
                    OFS_PTR: rdata = ptr_all[c*DATA_W +: DATA_W];
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bm_en,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]        drv_sel,
    input  logic [NUM_CH-1:0]        dma_done,
    output logic [NUM_CH-1:0]        dma_start,
    output logic [NUM_CH-1:0]        dma_abort,
    output logic [NUM_CH-1:0]        dma_unit,
    output logic [NUM_CH*DATA_W-1:0] dma_ptr
);
    chan_wr_t [NUM_CH-1:0]    wr;
    logic [NUM_CH*REG_W-1:0]  cmd_all;
    logic [NUM_CH*REG_W-1:0]  sts_all;

    bmdma_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
        .bm_en     (bm_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .wr        (wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bmdma_chan ch_i (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr[c]),
            .wdata   (req_wdata),
            .done    (dma_done[c]),
            .drv_sel (drv_sel[c]),
            .cmd_q   (cmd_all[c*REG_W +: REG_W]),
            .sts_q   (sts_all[c*REG_W +: REG_W]),
            .ptr_q   (dma_ptr[c*DATA_W +: DATA_W]),
            .start_p (dma_start[c]),
            .abort_p (dma_abort[c]),
            .unit_q  (dma_unit[c])
        );
    end

    bmdma_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) rd_i (
        .addr    (req_addr),
        .cmd_all (cmd_all),
        .sts_all (sts_all),
        .ptr_all (dma_ptr),
        .rdata   (rd_data)
    );
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bm_en,
    input logic [NUM_CH-1:0]        dma_done,
    input logic [NUM_CH-1:0]        dma_start,
    input logic [NUM_CH-1:0]        dma_abort,
    input logic [NUM_CH*REG_W-1:0]  cmd_all,
    input logic [NUM_CH*REG_W-1:0]  sts_all,
    input logic [NUM_CH*DATA_W-1:0] dma_ptr
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_GATED_WRITES: assert property (@(posedge clk) disable iff (rst)
            (!bm_en && !dma_done[c]) |=> ($stable(cmd_all[c*REG_W +: REG_W]) &&
                                          $stable(sts_all[c*REG_W +: REG_W]) &&
                                          $stable(dma_ptr[c*DATA_W +: DATA_W]))); // R2
        AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (rst)
            $past(cmd_all[c*REG_W + CMD_RUN]) |->
                (cmd_all[c*REG_W + CMD_DIR] == $past(cmd_all[c*REG_W + CMD_DIR]))); // R4
        AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
            $rose(cmd_all[c*REG_W + CMD_RUN]) |-> dma_start[c]); // R5
        AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
            ($fell(cmd_all[c*REG_W + CMD_RUN]) && !$past(dma_done[c])) |-> dma_abort[c]); // R6
        AST_ACT_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (rst)
            sts_all[c*REG_W + ST_ACT] == cmd_all[c*REG_W + CMD_RUN]); // R7
        AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
            dma_ptr[c*DATA_W +: 2] == 2'b00); // R9
        AST_DONE_UPDATE: assert property (@(posedge clk) disable iff (rst)
            dma_done[c] |=> (!cmd_all[c*REG_W + CMD_RUN] && !sts_all[c*REG_W + ST_ACT] &&
                             sts_all[c*REG_W + ST_IRQ])); // R10
        AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(dma_start[c] && dma_abort[c])); // R6
    end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bm_en     (bm_en),
    .dma_done  (dma_done),
    .dma_start (dma_start),
    .dma_abort (dma_abort),
    .cmd_all   (cmd_all),
    .sts_all   (sts_all),
    .dma_ptr   (dma_ptr)
);

// File: tb/bmdma_regfile_tb_top.sv
`timescale 1ns/1ps
module bmdma_regfile_tb_top;
    localparam int NCH = 2;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bm_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rd_data;
    logic [NCH-1:0] drv_sel = '0;
    logic [NCH-1:0] dma_done = '0;
    logic [NCH-1:0] dma_start, dma_abort, dma_unit;
    logic [NCH*32-1:0] dma_ptr;

    always #2.5 clk = ~clk;

    bmdma_regfile #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (.*);

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0]  m_cmd [NCH];
    logic [7:0]  m_sts [NCH];
    logic [31:0] m_ptr [NCH];
    logic        e_start [NCH];
    logic        e_abort [NCH];
    logic        m_unit [NCH];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input logic [7:0] cur, input logic [7:0] w);
        logic [7:0] r = w;
        if (cur[0]) r[3] = cur[3];
        return r;
    endfunction

    function automatic logic [7:0] exp_sts(input logic [7:0] cur, input logic [7:0] w);
        logic [7:0] r = w;
        r[0] = cur[0];
        r[1] = cur[1] & ~w[1];
        r[2] = cur[2] & ~w[2];
        return r;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_cmd[c] = 8'h00; m_sts[c] = 8'h60; m_ptr[c] = 0;
            e_start[c] = 0; e_abort[c] = 0; m_unit[c] = 0;
        end
    endtask

    // one clock of traffic; model updated from the requirements
    task automatic step(input logic v, input logic w, input int ch, input logic [2:0] ofs,
                        input logic [1:0] sz, input logic [31:0] d, input logic [NCH-1:0] dn);
        logic [7:0] nc;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = {ch[0], ofs};
        req_size = sz; req_wdata = d; dma_done = dn;
        for (int c = 0; c < NCH; c++) begin e_start[c] = 0; e_abort[c] = 0; end
        if (v && w && bm_en) begin
            if (ofs == 3'd0 && sz == 2'd0) begin
                nc = exp_cmd(m_cmd[ch], d[7:0]);
                if (!m_cmd[ch][0] && nc[0]) begin e_start[ch] = 1; m_sts[ch][0] = 1; m_unit[ch] = drv_sel[ch]; end
                if (m_cmd[ch][0] && !nc[0]) begin e_abort[ch] = 1; m_sts[ch][0] = 0; m_unit[ch] = drv_sel[ch]; end
                m_cmd[ch] = nc;
            end
            if (ofs == 3'd2 && sz == 2'd0) m_sts[ch] = exp_sts(m_sts[ch], d[7:0]);
            if (ofs == 3'd4 && sz == 2'd2) m_ptr[ch] = d & ~32'd3;
        end
        for (int c = 0; c < NCH; c++)
            if (dn[c]) begin
                m_cmd[c][0] = 0; m_sts[c][0] = 0; m_sts[c][2] = 1; e_start[c] = 0;
            end
        @(posedge clk);
        #1;
        req_valid = 0; req_write = 0; dma_done = '0;
        for (int c = 0; c < NCH; c++) begin
            check($sformatf("R5 start pulse ch%0d", c), 32'(dma_start[c]), 32'(e_start[c]));
            check($sformatf("R6 abort pulse ch%0d", c), 32'(dma_abort[c]), 32'(e_abort[c]));
            if (e_start[c] || e_abort[c])
                check($sformatf("R5 unit ch%0d", c), 32'(dma_unit[c]), 32'(m_unit[c]));
            if (e_start[c])
                check($sformatf("R5 pointer ch%0d", c), dma_ptr[c*32 +: 32], m_ptr[c]);
        end
    endtask

    task automatic rd_chk(input string tag, input int ch, input logic [2:0] ofs, input logic [31:0] exp);
        req_addr = {ch[0], ofs};
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            rd_chk({tag, " R4 cmd"}, c, 3'd0, 32'(m_cmd[c]));
            rd_chk({tag, " R8 sts"}, c, 3'd2, 32'(m_sts[c]));
            rd_chk({tag, " R9 ptr"}, c, 3'd4, m_ptr[c]);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check_all("R1 reset");
        rd_chk("R1 odd offset", 0, 3'd1, 32'h0);
        rd_chk("R1 odd offset", 1, 3'd6, 32'h0);

        // R2: gate off
        bm_en = 0;
        step(1, 1, 0, 3'd0, 2'd0, 32'h09, '0);
        step(1, 1, 1, 3'd4, 2'd2, 32'hABCD_0000, '0);
        check_all("R2 gated");

        bm_en = 1;
        // R3: wrong sizes to command
        step(1, 1, 0, 3'd0, 2'd1, 32'h08, '0);
        step(1, 1, 0, 3'd0, 2'd2, 32'h08, '0);
        check_all("R3 size");
        step(1, 1, 0, 3'd0, 2'd0, 32'h08, '0);
        rd_chk("R3 byte write", 0, 3'd0, 32'h08);

        // R9: pointer alignment and size
        step(1, 1, 0, 3'd4, 2'd2, 32'h1234_5677, '0);
        rd_chk("R9 aligned", 0, 3'd4, 32'h1234_5674);
        step(1, 1, 0, 3'd4, 2'd1, 32'hFFFF, '0);
        rd_chk("R9 half ignored", 0, 3'd4, 32'h1234_5674);

        // R5: start
        drv_sel = 2'b01;
        step(1, 1, 0, 3'd0, 2'd0, 32'h09, '0);
        rd_chk("R5 active set", 0, 3'd2, 32'h61);
        // R4: direction locked
        step(1, 1, 0, 3'd0, 2'd0, 32'h01, '0);
        rd_chk("R4 dir kept", 0, 3'd0, 32'h09);
        // R7: active cannot be cleared by status write
        step(1, 1, 0, 3'd2, 2'd0, 32'h00, '0);
        rd_chk("R7 active RO", 0, 3'd2, 32'h01);
        // R6: stop
        drv_sel = 2'b00;
        step(1, 1, 0, 3'd0, 2'd0, 32'h00, '0);
        rd_chk("R6 active clear", 0, 3'd2, 32'h00);
        // R7: writing 1 to active while idle leaves it 0
        step(1, 1, 0, 3'd2, 2'd0, 32'h61, '0);
        rd_chk("R7 active RO idle", 0, 3'd2, 32'h60);

        // R10: completion on channel 1
        drv_sel = 2'b10;
        step(1, 1, 1, 3'd0, 2'd0, 32'h01, '0);
        step(0, 0, 0, 3'd0, 2'd0, 32'h0, 2'b10);
        rd_chk("R10 run cleared", 1, 3'd0, 32'h00);
        rd_chk("R10 irq set", 1, 3'd2, 32'h64);
        // R8: write 0 keeps, write 1 clears
        step(1, 1, 1, 3'd2, 2'd0, 32'h60, '0);
        rd_chk("R8 zero keeps", 1, 3'd2, 32'h64);
        step(1, 1, 1, 3'd2, 2'd0, 32'h64, '0);
        rd_chk("R8 one clears", 1, 3'd2, 32'h60);
        // R11: completion beats same-cycle clear
        step(1, 1, 1, 3'd2, 2'd0, 32'h64, 2'b10);
        rd_chk("R11 irq kept", 1, 3'd2, 32'h64);
        check_all("R11 all");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            int ch;
            logic [2:0] ofs;
            logic [1:0] sz;
            logic [NCH-1:0] dn;
            bm_en   = ($urandom % 8) != 0;
            drv_sel = NCH'($urandom);
            ch  = int'($urandom % NCH);
            case ($urandom % 5)
                0: ofs = 3'd0;
                1: ofs = 3'd2;
                2: ofs = 3'd4;
                3: ofs = 3'd0;
                default: ofs = 3'(($urandom % 4) * 2 + 1);
            endcase
            sz = (($urandom % 4) == 0) ? 2'($urandom) : ((ofs == 3'd4) ? 2'd2 : 2'd0);
            dn = '0;
            for (int c = 0; c < NCH; c++) dn[c] = ($urandom % 8) == 0;
            step(1, ($urandom % 6) != 0, ch, ofs, sz, $urandom, dn);
            check_all("RND");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule